// File: doc/BRIEF.md
# Serial Clock-Calendar Register Slave

This block is the serial front end of a small clock-calendar. It presents a file of sixteen 8-bit locations to a host over a four-wire serial link. The link has a serial clock, an active-high select, host-to-device data and device-to-host data. Addresses 0 to 6 hold the time set: seconds, minutes, hours, weekday, day of month, month and year. Address 14 is a mode register and address 15 is a status register. Addresses 7 to 13 are plain storage.

Each transfer opens with a command byte. The command carries the start address and the access kind: single or burst, read or write. Data bytes follow. In a burst the address steps forward after every byte, so one select window can move the whole time set without tearing.

The block talks to a timekeeping core through a parallel port. The core's time set is latched when a read command is decoded. After a transfer that wrote any time location, the shadow time set is handed back to the core with a one-cycle load strobe.

All serial inputs are brought into the system clock domain through a synchronizer. Edges of the serial clock are detected in that domain.

Top module: `spi_rtc_regslave`

## Requirements
- R1: The serial link uses clock mode 1 with an active-high select. The host-to-device bit is sampled on the falling edge of the serial clock. The device-to-host bit changes only after a rising edge. Bytes travel MSB first. While select is low, the device-to-host line is 0.
- R2: The command byte is decoded as follows. Bits 7:4 are the start address. Bit 3 set means single access and bit 3 clear means burst. Bit 2 set means read and bit 2 clear means write. Bits 1:0 are ignored.
- R3: In a burst, the address moves to the next location after each complete data byte, and it wraps from 15 to 0.
- R4: In a single access, only the first data byte takes effect. For a write, later bytes change no location. For a read, later bytes are returned as 0.
- R5: When select falls, the bit count and the command state are cleared and any partial byte is dropped. The next select window starts with a fresh command byte.
- R6: When a read command is decoded, locations 0 to 6 are loaded from `core_time_i`, with byte k at bits 8k+7:8k. Changes on `core_time_i` later in the same transfer do not change the bytes returned.
- R7: Bit 7 of the seconds location (address 0) always reads 0, whether the value came from a host write or from a snapshot.
- R8: If a transfer completes a write to any of locations 0 to 6, `core_load_o` pulses for exactly one cycle after select falls. During that cycle `core_time_o` carries locations 0 to 6, with byte k at bits 8k+7:8k. A transfer that writes no time location gives no pulse.
- R9: In the status register (address 15), bit 4 is the oscillator-stop flag and bit 6 is the low-voltage flag. Bit 4 is set by reset and while `core_osc_stop_i` is high. Bit 6 is set while `core_vlow_i` is high. A host write stores the written bits, so writing 0 clears a flag.
- R10: Bit 5 of the mode register (address 14) drives `mode_24h_o`. A 1 selects the 24-hour format.
- R11: After reset, every location is 0 except the status register, which holds 0x10. `miso_o`, `core_load_o` and `mode_24h_o` are 0.
- R12: Locations 7 to 13 keep whatever the host last wrote to them, and read it back unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sclk_i | input | 1 | Serial clock from the host |
| cs_i | input | 1 | Active-high select from the host |
| mosi_i | input | 1 | Host-to-device serial data |
| miso_o | output | 1 | Device-to-host serial data |
| core_time_i | input | 56 | Current time set from the core, byte k at bits 8k+7:8k |
| core_osc_stop_i | input | 1 | Oscillator-stop indication from the core |
| core_vlow_i | input | 1 | Low-voltage indication from the core |
| core_load_o | output | 1 | One-cycle strobe: load the time set into the core |
| core_time_o | output | 56 | Shadow time set for the core, byte k at bits 8k+7:8k |
| mode_24h_o | output | 1 | 24-hour format select |

## Verification
The assertions assume that the host keeps each serial clock phase at least four system clocks long. This gives a decoded command or a finished data byte time to settle before the next rising edge. They also assume that select stays low for at least two system clocks between transfers, so the load strobe is seen while select is still low. The bench drives every serial input on the falling system clock edge. It holds each serial clock phase for five system clocks and keeps select low for eight clocks between transfers. Random transfers use only these timings, while addresses, access kinds, lengths, trailing partial bytes and core time values vary freely.

// File: rtl/spi_rtc_pkg.sv
// Package: shared constants and types of the serial clock-calendar slave.
// Assumes 8-bit locations and a 4-bit address packed in the command's upper nibble.
package spi_rtc_pkg;

    typedef enum logic [1:0] {
        ST_CMD  = 2'd0,   // waiting for the command byte
        ST_DATA = 2'd1,   // data bytes take effect
        ST_DONE = 2'd2    // single access finished, later bytes ignored
    } xfer_state_e;

    localparam int unsigned CMD_SINGLE_BIT = 3;   // 1 = single, 0 = burst
    localparam int unsigned CMD_READ_BIT   = 2;   // 1 = read,   0 = write

    localparam int unsigned SEC_LOC   = 0;
    localparam int unsigned MODE_LOC  = 14;
    localparam int unsigned STAT_LOC  = 15;

    localparam int unsigned SEC_MSB_BIT  = 7;
    localparam int unsigned H24_BIT      = 5;
    localparam int unsigned OSC_STOP_BIT = 4;
    localparam int unsigned VLOW_BIT     = 6;

endpackage

// File: rtl/spi_rtc_sync.sv
// Module: multi-stage synchronizer for a bundle of asynchronous inputs.
// Assumes each input is held long enough to be seen by the system clock.
module spi_rtc_sync #(
    parameter int unsigned STAGES = 2,
    parameter int unsigned WIDTH  = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] level_o
);

    logic [WIDTH-1:0] pipe [STAGES];

    // Purpose: shift the raw inputs through the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < int'(STAGES); i++) pipe[i] <= '0;
        end else begin
            pipe[0] <= async_i;
            for (int i = 1; i < int'(STAGES); i++) pipe[i] <= pipe[i-1];
        end
    end

    assign level_o = pipe[STAGES-1];

endmodule

// File: rtl/spi_rtc_shifter.sv
// Module: bit-level engine in clock mode 1. Samples host data on the falling edge
// and shifts device data out on the rising edge, MSB first.
// Assumes edge pulses that are already synchronized. A rising edge seen with the
// bit count at 0 opens a new byte and takes a fresh value from rd_data_i.
module spi_rtc_shifter #(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_i,
    input  logic              sclk_rise_i,
    input  logic              sclk_fall_i,
    input  logic              mosi_i,
    input  logic [DATA_W-1:0] rd_data_i,
    output logic              miso_o,
    output logic              byte_done_o,
    output logic [DATA_W-1:0] rx_byte_o
);

    localparam int unsigned CNT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);

    logic [CNT_W-1:0]  bit_cnt;
    logic [DATA_W-1:0] rx_sh;
    logic [DATA_W-1:0] tx_sh;

    // Purpose: collect host bits on falling edges and flag each whole byte.
    always_ff @(posedge clk) begin
        if (!rst_n || !cs_i) begin
            bit_cnt     <= '0;
            rx_sh       <= '0;
            byte_done_o <= 1'b0;
            if (!rst_n) rx_byte_o <= '0;
        end else begin
            byte_done_o <= 1'b0;
            if (sclk_fall_i) begin
                rx_sh <= {rx_sh[DATA_W-2:0], mosi_i};
                if (bit_cnt == LAST_BIT) begin
                    bit_cnt     <= '0;
                    byte_done_o <= 1'b1;
                    rx_byte_o   <= {rx_sh[DATA_W-2:0], mosi_i};
                end else begin
                    bit_cnt <= bit_cnt + CNT_W'(1);
                end
            end
        end
    end

    // Purpose: drive device bits after rising edges, reloading at byte starts.
    always_ff @(posedge clk) begin
        if (!rst_n || !cs_i) begin
            miso_o <= 1'b0;
            tx_sh  <= '0;
        end else if (sclk_rise_i) begin
            if (bit_cnt == '0) begin
                miso_o <= rd_data_i[DATA_W-1];
                tx_sh  <= {rd_data_i[DATA_W-2:0], 1'b0};
            end else begin
                miso_o <= tx_sh[DATA_W-1];
                tx_sh  <= {tx_sh[DATA_W-2:0], 1'b0};
            end
        end
    end

    // R5: a dropped select clears the bit count and suppresses byte completion
    a_r5_cnt_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_i |=> (bit_cnt == '0) && !byte_done_o);

    // R1: device line is idle while select is low
    a_r1_miso_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_i |=> !miso_o);

    // R1: device line moves only after a rising serial clock edge
    a_r1_miso_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_i && !sclk_rise_i) |=> $stable(miso_o));

endmodule

// File: rtl/spi_rtc_cmd_fsm.sv
// Module: transaction control. Decodes the command byte, steps the address in
// bursts, ends single accesses after one data byte, and raises the core load
// strobe when select falls after a write to a time location.
// Assumes byte_done_i pulses only while select is high.
module spi_rtc_cmd_fsm
    import spi_rtc_pkg::*;
#(
    parameter int unsigned ADDR_W   = 4,
    parameter int unsigned NUM_TIME = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_i,
    input  logic              cs_fall_i,
    input  logic              byte_done_i,
    input  logic [ADDR_W-1:0] cmd_addr_i,
    input  logic              cmd_single_i,
    input  logic              cmd_read_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic              wr_en_o,
    output logic              snap_en_o,
    output logic              rd_active_o,
    output logic              core_load_o
);

    localparam logic [ADDR_W-1:0] TIME_LIM = ADDR_W'(NUM_TIME);

    xfer_state_e state;
    logic        is_read;
    logic        is_single;
    logic        dirty;
    logic        cmd_now;
    logic        data_now;

    // Purpose: classify the current byte completion by transaction phase.
    always_comb begin
        cmd_now     = (state == ST_CMD)  && byte_done_i;
        data_now    = (state == ST_DATA) && byte_done_i;
        wr_en_o     = data_now && !is_read;
        snap_en_o   = cmd_now && cmd_read_i;
        rd_active_o = (state == ST_DATA) && is_read;
    end

    // Purpose: advance the transaction phase and the working address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_CMD;
            addr_o    <= '0;
            is_read   <= 1'b0;
            is_single <= 1'b0;
        end else if (!cs_i) begin
            state <= ST_CMD;
        end else if (cmd_now) begin
            addr_o    <= cmd_addr_i;
            is_read   <= cmd_read_i;
            is_single <= cmd_single_i;
            state     <= ST_DATA;
        end else if (data_now) begin
            if (is_single) state <= ST_DONE;
            else           addr_o <= addr_o + ADDR_W'(1);
        end
    end

    // Purpose: remember time writes and issue the load strobe at select release.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dirty       <= 1'b0;
            core_load_o <= 1'b0;
        end else begin
            core_load_o <= cs_fall_i && dirty;
            if (cs_fall_i)                          dirty <= 1'b0;
            else if (wr_en_o && addr_o < TIME_LIM)  dirty <= 1'b1;
        end
    end

    // R3: a burst data byte moves the address to the next location
    a_r3_burst_step: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_i && data_now && !is_single) |=> addr_o == $past(addr_o) + ADDR_W'(1));

    // R4: a single access leaves the data phase after its first data byte
    a_r4_single_ends: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_i && data_now && is_single) |=> state != ST_DATA);

    // R8: the load strobe lasts one cycle
    a_r8_load_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        core_load_o |=> !core_load_o);

    // R8: the load strobe appears only with select low
    a_r8_load_cs_low: assert property (@(posedge clk) disable iff (!rst_n)
        core_load_o |-> !cs_i);

endmodule

// File: rtl/spi_rtc_regfile.sv
// Module: sixteen-location register file with a time snapshot port, status flag
// set inputs and the seconds MSB forced to zero.
// Assumes snapshot and host write never fall in the same cycle.
module spi_rtc_regfile
    import spi_rtc_pkg::*;
#(
    parameter int unsigned ADDR_W   = 4,
    parameter int unsigned DATA_W   = 8,
    parameter int unsigned NUM_TIME = 7
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en_i,
    input  logic [ADDR_W-1:0]          addr_i,
    input  logic [DATA_W-1:0]          wr_data_i,
    input  logic                       snap_en_i,
    input  logic [NUM_TIME*DATA_W-1:0] snap_data_i,
    input  logic                       osc_stop_i,
    input  logic                       vlow_i,
    output logic [DATA_W-1:0]          rd_data_o,
    output logic [NUM_TIME*DATA_W-1:0] time_o,
    output logic                       mode_24h_o
);

    localparam int unsigned NUM_LOCS = 1 << ADDR_W;
    localparam logic [ADDR_W-1:0] SEC_A  = ADDR_W'(SEC_LOC);
    localparam logic [ADDR_W-1:0] MODE_A = ADDR_W'(MODE_LOC);
    localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'(STAT_LOC);
    localparam logic [DATA_W-1:0] SEC_MASK = ~(DATA_W'(1) << SEC_MSB_BIT);
    localparam logic [DATA_W-1:0] STAT_RST = DATA_W'(1) << OSC_STOP_BIT;

    logic [DATA_W-1:0] locs [NUM_LOCS];
    logic [DATA_W-1:0] wr_val;

    // Purpose: apply the seconds MSB mask to host write data.
    always_comb begin
        wr_val = (addr_i == SEC_A) ? (wr_data_i & SEC_MASK) : wr_data_i;
    end

    // Purpose: update locations from snapshot, host write and status flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < int'(NUM_LOCS); i++) locs[i] <= '0;
            locs[STAT_A] <= STAT_RST;
        end else begin
            if (snap_en_i) begin
                for (int k = 0; k < int'(NUM_TIME); k++)
                    locs[k] <= (k == int'(SEC_LOC))
                             ? (snap_data_i[k*DATA_W +: DATA_W] & SEC_MASK)
                             : snap_data_i[k*DATA_W +: DATA_W];
            end
            if (wr_en_i) locs[addr_i] <= wr_val;
            if (osc_stop_i) locs[STAT_A][OSC_STOP_BIT] <= 1'b1;
            if (vlow_i)     locs[STAT_A][VLOW_BIT]     <= 1'b1;
        end
    end

    assign rd_data_o  = locs[addr_i];
    assign mode_24h_o = locs[MODE_A][H24_BIT];

    generate
        for (genvar g = 0; g < int'(NUM_TIME); g++) begin : g_time_out
            assign time_o[g*DATA_W +: DATA_W] = locs[g];
        end
    endgenerate

    // R7: seconds MSB never holds a one
    a_r7_sec_msb_clear: assert property (@(posedge clk) disable iff (!rst_n)
        !locs[SEC_A][SEC_MSB_BIT]);

    // R9: oscillator-stop indication sets the status flag
    a_r9_osc_sets: assert property (@(posedge clk) disable iff (!rst_n)
        osc_stop_i |=> locs[STAT_A][OSC_STOP_BIT]);

    // R9: low-voltage indication sets the status flag
    a_r9_vlow_sets: assert property (@(posedge clk) disable iff (!rst_n)
        vlow_i |=> locs[STAT_A][VLOW_BIT]);

    // R6: snapshot captures the core's minutes byte
    a_r6_snap_minutes: assert property (@(posedge clk) disable iff (!rst_n)
        snap_en_i |=> locs[1] == $past(snap_data_i[DATA_W +: DATA_W]));

endmodule

// File: rtl/spi_rtc_regslave.sv
// Module: top of the serial clock-calendar register slave. Synchronizes the
// serial inputs, detects serial clock and select edges, and joins the shifter,
// the transaction control and the register file.
// Assumes each serial clock phase lasts at least four system clocks.
module spi_rtc_regslave
    import spi_rtc_pkg::*;
#(
    parameter int unsigned ADDR_W      = 4,
    parameter int unsigned DATA_W      = 8,
    parameter int unsigned NUM_TIME    = 7,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       sclk_i,
    input  logic                       cs_i,
    input  logic                       mosi_i,
    output logic                       miso_o,
    input  logic [NUM_TIME*DATA_W-1:0] core_time_i,
    input  logic                       core_osc_stop_i,
    input  logic                       core_vlow_i,
    output logic                       core_load_o,
    output logic [NUM_TIME*DATA_W-1:0] core_time_o,
    output logic                       mode_24h_o
);

    localparam int unsigned IDX_CS   = 0;
    localparam int unsigned IDX_SCLK = 1;
    localparam int unsigned IDX_MOSI = 2;

    logic [2:0]        sync_lvl;
    logic [1:0]        edge_prev;
    logic              cs_s, sclk_rise, sclk_fall, cs_fall;
    logic              byte_done;
    logic [DATA_W-1:0] rx_byte;
    logic [DATA_W-1:0] loc_data;
    logic [DATA_W-1:0] tx_data;
    logic [ADDR_W-1:0] addr;
    logic              wr_en, snap_en, rd_active;

    spi_rtc_sync #(.STAGES(SYNC_STAGES), .WIDTH(3)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({mosi_i, sclk_i, cs_i}),
        .level_o (sync_lvl)
    );

    // Purpose: keep the last synchronized select and serial clock for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) edge_prev <= '0;
        else        edge_prev <= {sync_lvl[IDX_SCLK], sync_lvl[IDX_CS]};
    end

    // Purpose: derive select level and edge pulses.
    always_comb begin
        cs_s      = sync_lvl[IDX_CS];
        sclk_rise =  sync_lvl[IDX_SCLK] && !edge_prev[1];
        sclk_fall = !sync_lvl[IDX_SCLK] &&  edge_prev[1];
        cs_fall   = !sync_lvl[IDX_CS]   &&  edge_prev[0];
        tx_data   = rd_active ? loc_data : '0;
    end

    spi_rtc_shifter #(.DATA_W(DATA_W)) u_shift (
        .clk         (clk),
        .rst_n       (rst_n),
        .cs_i        (cs_s),
        .sclk_rise_i (sclk_rise),
        .sclk_fall_i (sclk_fall),
        .mosi_i      (sync_lvl[IDX_MOSI]),
        .rd_data_i   (tx_data),
        .miso_o      (miso_o),
        .byte_done_o (byte_done),
        .rx_byte_o   (rx_byte)
    );

    spi_rtc_cmd_fsm #(.ADDR_W(ADDR_W), .NUM_TIME(NUM_TIME)) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .cs_i         (cs_s),
        .cs_fall_i    (cs_fall),
        .byte_done_i  (byte_done),
        .cmd_addr_i   (rx_byte[DATA_W-1 -: ADDR_W]),
        .cmd_single_i (rx_byte[CMD_SINGLE_BIT]),
        .cmd_read_i   (rx_byte[CMD_READ_BIT]),
        .addr_o       (addr),
        .wr_en_o      (wr_en),
        .snap_en_o    (snap_en),
        .rd_active_o  (rd_active),
        .core_load_o  (core_load_o)
    );

    spi_rtc_regfile #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_TIME(NUM_TIME)) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en_i     (wr_en),
        .addr_i      (addr),
        .wr_data_i   (rx_byte),
        .snap_en_i   (snap_en),
        .snap_data_i (core_time_i),
        .osc_stop_i  (core_osc_stop_i),
        .vlow_i      (core_vlow_i),
        .rd_data_o   (loc_data),
        .time_o      (core_time_o),
        .mode_24h_o  (mode_24h_o)
    );

    // R2: a write never coincides with a snapshot
    a_r2_no_snap_on_write: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && snap_en));

endmodule

// File: tb/spi_rtc_regslave_test.sv
module spi_rtc_regslave_test;

    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sclk = 1'b0, cs = 1'b0, mosi = 1'b0;
    logic        miso;
    logic [55:0] core_t;
    logic        osc = 1'b0, vlow = 1'b0;
    logic        load;
    logic [55:0] tout;
    logic        h24;

    int checks = 0, failures = 0, load_cnt = 0;
    bit finished = 0;

    logic [7:0] mdl   [16];
    logic [7:0] txd   [8];
    logic [7:0] rxd   [8];
    logic [7:0] exp_rx[8];

    always #(CLK_PERIOD/2) clk = ~clk;

    spi_rtc_regslave uut (
        .clk(clk), .rst_n(rst_n), .sclk_i(sclk), .cs_i(cs), .mosi_i(mosi),
        .miso_o(miso), .core_time_i(core_t), .core_osc_stop_i(osc),
        .core_vlow_i(vlow), .core_load_o(load), .core_time_o(tout),
        .mode_24h_o(h24)
    );

    // core model: takes the time set on each load strobe
    always @(posedge clk) begin
        if (load) begin
            core_t   <= tout;
            load_cnt <= load_cnt + 1;
        end
    end

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [55:0] mdl_time();
        logic [55:0] t;
        for (int k = 0; k < 7; k++) t[k*8 +: 8] = mdl[k];
        return t;
    endfunction

    task automatic spi_byte(input logic [7:0] b, output logic [7:0] r);
        for (int i = 7; i >= 0; i--) begin
            @(negedge clk);
            sclk = 1'b1; mosi = b[i];
            repeat (HALF) @(negedge clk);
            r[i] = miso;
            sclk = 1'b0;
            repeat (HALF-1) @(negedge clk);
        end
    endtask

    task automatic spi_bits(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            sclk = 1'b1; mosi = 1'b1;
            repeat (HALF) @(negedge clk);
            sclk = 1'b0;
            repeat (HALF-1) @(negedge clk);
        end
    endtask

    task automatic cs_on();
        @(negedge clk); cs = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    task automatic cs_off();
        repeat (2) @(negedge clk);
        cs = 1'b0;
        repeat (8) @(negedge clk);
    endtask

    // reference model of one transfer (R2, R3, R4, R6, R7, R8, R12)
    task automatic model_xfer(input logic [7:0] cmd, input int n, output bit exp_load);
        logic [3:0] a, ad;
        bit single, rd;
        a = cmd[7:4]; single = cmd[3]; rd = cmd[2]; exp_load = 0;
        if (rd) begin
            for (int k = 0; k < 7; k++) mdl[k] = core_t[k*8 +: 8];
            mdl[0][7] = 1'b0;
        end
        for (int i = 0; i < n; i++) begin
            ad = single ? a : a + 4'(i);
            if (single && i > 0) exp_rx[i] = 8'h00;
            else if (rd) exp_rx[i] = mdl[ad];
            else begin
                mdl[ad] = (ad == 4'd0) ? (txd[i] & 8'h7F) : txd[i];
                if (ad < 4'd7) exp_load = 1;
            end
        end
    endtask

    task automatic run_xfer(input logic [7:0] cmd, input int n, input int partial, input string req);
        bit el;
        int lc;
        logic [7:0] dummy;
        model_xfer(cmd, n, el);
        lc = load_cnt;
        cs_on();
        spi_byte(cmd, dummy);
        for (int i = 0; i < n; i++) spi_byte(txd[i], rxd[i]);
        if (partial > 0) spi_bits(partial);
        cs_off();
        if (cmd[2]) for (int i = 0; i < n; i++) check(req, rxd[i], exp_rx[i]);
        check("R8 load count", 64'(load_cnt - lc), 64'(el));
        if (el) check("R8 load value", core_t, mdl_time());
        check("R10 mode_24h", h24, mdl[14][5]);
    endtask

    task automatic read1(input logic [3:0] a, input logic [7:0] exp, input string req);
        logic [7:0] cmd;
        cmd = {a, 4'hC};
        txd[0] = 8'h00;
        run_xfer(cmd, 1, 0, req);
        check(req, rxd[0], exp);
    endtask

    task automatic write1(input logic [3:0] a, input logic [7:0] d, input string req);
        txd[0] = d;
        run_xfer({a, 4'h8}, 1, 0, req);
    endtask

    initial begin
        logic [7:0] dummy;
        bit el;
        void'($urandom(32'd20240611));
        core_t = {8'h24, 8'h06, 8'h15, 8'h02, 8'h11, 8'h34, 8'hD9};
        for (int i = 0; i < 16; i++) mdl[i] = 8'h00;
        mdl[15] = 8'h10;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R11: reset state
        check("R11 miso", miso, 1'b0);
        check("R11 load", load, 1'b0);
        check("R11 mode_24h", h24, 1'b0);
        check("R11 time out", tout, 56'h0);
        read1(4'd15, 8'h10, "R11 R9 status reset");
        read1(4'd9, 8'h00, "R11 scratch reset");

        // R7: seconds MSB reads 0 from a snapshot (core holds 0xD9)
        read1(4'd0, 8'h59, "R7 seconds msb");

        // R2: bits 1:0 ignored, 0xF low nibble is a single read
        txd[0] = 8'h00;
        run_xfer({4'd2, 4'hF}, 1, 0, "R2 cmd low bits");
        check("R2 cmd low bits", rxd[0], 8'h11);

        // R6: snapshot is not torn by a mid-transfer core change
        model_xfer(8'h04, 7, el);
        cs_on();
        spi_byte(8'h04, dummy);
        for (int i = 0; i < 7; i++) begin
            if (i == 2) core_t = 56'h99_12_31_06_23_59_58;
            spi_byte(8'h00, rxd[i]);
        end
        cs_off();
        for (int i = 0; i < 7; i++) check("R6 R3 burst read snapshot", rxd[i], exp_rx[i]);

        // R8: burst write of the time set loads the core
        for (int i = 0; i < 7; i++) txd[i] = 8'h10 + 8'(i);
        txd[0] = 8'hC5;
        run_xfer(8'h00, 7, 0, "R8 burst write");
        check("R7 R8 seconds masked to core", core_t[7:0], 8'h45);
        for (int i = 0; i < 7; i++) txd[i] = 8'h00;
        run_xfer(8'h04, 7, 0, "R8 read back after load");

        // R10: mode register bit 5, no load for non-time write
        write1(4'd14, 8'h20, "R10 write mode");
        check("R10 mode on", h24, 1'b1);

        // R3: burst write wraps from 15 to 0
        txd[0] = 8'h20; txd[1] = 8'h00; txd[2] = 8'h33; txd[3] = 8'h07;
        run_xfer(8'hE0, 4, 0, "R3 wrap write");
        check("R3 wrap sec", core_t[7:0], 8'h33);
        check("R3 wrap min", core_t[15:8], 8'h07);

        // R4, R12: single write ignores later bytes
        write1(4'd10, 8'hA5, "R12 preset");
        txd[0] = 8'h3C; txd[1] = 8'hFF; txd[2] = 8'hEE;
        run_xfer({4'd9, 4'h8}, 3, 0, "R4 single write");
        read1(4'd9, 8'h3C, "R12 scratch value");
        read1(4'd10, 8'hA5, "R4 neighbour untouched");
        // R4: single read returns 0 after the first byte
        for (int i = 0; i < 3; i++) txd[i] = 8'h00;
        run_xfer({4'd9, 4'hC}, 3, 0, "R4 single read tail");

        // R5: partial command byte dropped, next transfer decodes fresh
        cs_on(); spi_bits(5); cs_off();
        read1(4'd9, 8'h3C, "R5 after partial cmd");
        txd[0] = 8'h77;
        run_xfer({4'd11, 4'h8}, 0, 6, "R5 partial data");
        read1(4'd11, 8'h00, "R5 partial data dropped");

        // R9: flags set by core, cleared by host write
        write1(4'd15, 8'h00, "R9 clear");
        read1(4'd15, 8'h00, "R9 cleared");
        @(negedge clk); osc = 1'b1; repeat (3) @(negedge clk); osc = 1'b0;
        mdl[15] = 8'h10;
        read1(4'd15, 8'h10, "R9 osc flag");
        @(negedge clk); vlow = 1'b1; repeat (3) @(negedge clk); vlow = 1'b0;
        mdl[15] = 8'h50;
        read1(4'd15, 8'h50, "R9 vlow flag");

        // random transfers (R2, R3, R4, R5, R6, R8, R12)
        for (int t = 0; t < 110; t++) begin
            logic [7:0] cmd;
            int n, part;
            cmd[7:4] = 4'($urandom);
            cmd[3:2] = 2'($urandom);
            cmd[1:0] = 2'($urandom);
            n = 1 + int'($urandom % 4);
            part = ($urandom % 4 == 0) ? 1 + int'($urandom % 7) : 0;
            for (int i = 0; i < 8; i++) txd[i] = 8'($urandom);
            if ($urandom % 3 == 0) core_t = {$urandom, $urandom}[55:0];
            run_xfer(cmd, n, part, cmd[3] ? "R4 R2 random single" : "R3 R2 random burst");
        end

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule